// File: doc/BRIEF.md
# Byte-Lane Write Control and Parity Front End

This block sits between the pins of a synchronous SRAM and its storage array. It captures the write controls on each rising clock edge and turns them into one write strobe per byte lane. A global write forces every lane to be written. A byte write writes only the lanes whose select strobe is low. Each lane is 9 bits wide: 8 data bits and one parity bit.

On writes the block computes the parity bit from the lane's data, in the sense chosen by a sense input. On reads it checks each 9-bit lane coming back from the array against the same sense. A failed lane pulls an open-drain style error output low for exactly the beat that carried the bad data.

A mode input turns the parity lane off. The block then behaves as an 8-bit-per-lane part: parity bits are written as zero and the error output stays released. Every control, data and mode input is registered once, so each result appears one cycle after the edge that sampled it.

Top module: `bwp_front`

## Requirements
- R1: Every input is sampled on the rising clock edge. Strobes, write data, read data and the error flag for that sample are presented together, one cycle later, and change every cycle with the inputs.
- R2: When `globalWrN` is low, `laneWe` is all ones whatever `byteWrN` and `laneSelN` say.
- R3: When `globalWrN` is high and `byteWrN` is low, `laneWe[i]` is 1 exactly for the lanes where `laneSelN[i]` is low. With no select low, no lane is written.
- R4: When both `globalWrN` and `byteWrN` are high, `laneWe` is zero whatever the selects are.
- R5: With parity enabled (`parityEnN` low), lane i of `arrayWrData` is bits [9i+8:9i]. Bits [9i+7:9i] are the write data bits [8i+7:8i], and bit 9i+8 is the parity bit. For even sense (`evenSel` high) the parity bit is the XOR of the 8 data bits. For odd sense (`evenSel` low) it is the inverse of that XOR.
- R6: With parity disabled (`parityEnN` high), every parity bit position of `arrayWrData` is written 0, and the data bits are still placed as in R5.
- R7: With parity enabled and a read beat sampled, `parErrN` is driven low in the cycle that beat appears if any lane of `rdWord` has the wrong parity. For even sense, a lane fails when its 9 bits hold an odd number of ones; for odd sense, when they hold an even number. `parErrN` is low for that one cycle only.
- R8: With parity disabled, `parErrN` stays high even when the read lanes have bad parity.
- R9: While `rstN` is low, `laneWe` is zero, `rdBeatValid` is low and `parErrN` is high.
- R10: `rdBeatValid` is high one cycle after `rdValid` was sampled high. `rdBeatData` then carries bits [9i+7:9i] of the sampled `rdWord` in bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Byte-write enable, active low |
| laneSelN | input | LANES | Per-lane byte select, active low |
| parityEnN | input | 1 | Parity lane enable, active low |
| evenSel | input | 1 | Parity sense: 1 even, 0 odd |
| wrData | input | LANES*8 | Write data from the pins |
| rdValid | input | 1 | A read word is on rdWord this cycle |
| rdWord | input | LANES*9 | Read word from the array |
| laneWe | output | LANES | Per-lane array write strobe |
| arrayWrData | output | LANES*9 | Write word to the array, parity in bit 8 of each lane |
| rdBeatValid | output | 1 | Read beat present |
| rdBeatData | output | LANES*8 | Read data with parity stripped |
| parErrN | output | 1 | Open-drain pull-down enable, low on parity error |

## Verification
The bench targets four cases that are easy to get wrong.

A global write issued with a partial byte select must still write all lanes. A design that let the selects win would drop lanes.

Odd sense must invert both the generated bit and the check. A design that inverted only one side would flag every clean odd-parity read.

A single corrupted lane in the middle of the word must raise the flag, and the flag must drop on the following clean beat. A stuck or late flag would show up on the wrong beat.

With parity turned off, the bench writes data and reads deliberately corrupted lanes. It expects zero parity bits and a released flag, which catches designs that keep checking in 8-bit mode.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  // Strobes the control path hands to the datapath, valid one cycle after sampling.
  typedef struct packed {
    logic parityOn;   // parity lane in use
    logic evenSense;  // 1 even, 0 odd
    logic rdFire;     // a read beat is in the datapath register
  } bwpStrobes_t;
endpackage

// File: rtl/bwp_ctrl.sv
module bwp_ctrl
  import bwp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalWrN,
  input  logic             byteWrN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             parityEnN,
  input  logic             evenSel,
  input  logic             rdValid,
  output logic [LANES-1:0] laneWe,
  output bwpStrobes_t      strb
);

  logic [LANES-1:0] weNext;

  // Per-lane write decode: global write overrides the byte selects.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (!globalWrN)    weNext[i] = 1'b1;
      else if (!byteWrN) weNext[i] = !laneSelN[i];
      else               weNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneWe         <= '0;
      strb.parityOn  <= 1'b0;
      strb.evenSense <= 1'b0;
      strb.rdFire    <= 1'b0;
    end else begin
      laneWe         <= weNext;
      strb.parityOn  <= !parityEnN;
      strb.evenSense <= evenSel;
      strb.rdFire    <= rdValid;
    end
  end

  // R2: a global write reaches every lane.
  a_r2_global_all: assert property (@(posedge clk) disable iff (!rstN)
    !globalWrN |=> (&laneWe));

  // R3: a byte write reaches exactly the selected lanes.
  a_r3_selected_only: assert property (@(posedge clk) disable iff (!rstN)
    (globalWrN && !byteWrN) |=> (laneWe == ~$past(laneSelN)));

  // R4: no write enable, no strobe.
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (globalWrN && byteWrN) |=> (laneWe == '0));

endmodule

// File: rtl/bwp_datapath.sv
module bwp_datapath
  import bwp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bwpStrobes_t          strb,
  input  logic [LANES*8-1:0]   wrData,
  input  logic [LANES*9-1:0]   rdWord,
  output logic [LANES*9-1:0]   arrayWrData,
  output logic                 rdBeatValid,
  output logic [LANES*8-1:0]   rdBeatData,
  output logic                 parErrN
);

  localparam int DW = LANES * 8;
  localparam int AW = LANES * 9;

  logic [DW-1:0]    wrQ;
  logic [AW-1:0]    rdQ;
  logic [LANES-1:0] laneBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ <= '0;
      rdQ <= '0;
    end else begin
      wrQ <= wrData;
      rdQ <= rdWord;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] wd;
    logic [8:0] rl;
    logic       genPar;
    assign wd     = wrQ[8*i +: 8];
    assign rl     = rdQ[9*i +: 9];
    // Even sense: XOR of data; odd sense: its inverse. Zero when parity is off.
    assign genPar = strb.parityOn & ((^wd) ^ !strb.evenSense);
    assign arrayWrData[9*i +: 9] = {genPar, wd};
    assign rdBeatData[8*i +: 8]  = rl[7:0];
    assign laneBad[i] = (^rl) ^ !strb.evenSense;

    // R6: parity bits are zero while the parity lane is off.
    a_r6_par_zero: assert property (@(posedge clk) disable iff (!rstN)
      !strb.parityOn |-> !arrayWrData[9*i+8]);
  end

  assign rdBeatValid = strb.rdFire;
  assign parErrN     = !(strb.rdFire && strb.parityOn && (|laneBad));

  // R8: flag stays released with parity off.
  a_r8_released_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.parityOn |-> parErrN);

  // R7: the flag only ever accompanies a read beat.
  a_r7_err_on_beat: assert property (@(posedge clk) disable iff (!rstN)
    !parErrN |-> rdBeatValid);

  // R5: with even sense the whole generated word holds an even number of ones.
  a_r5_even_word: assert property (@(posedge clk) disable iff (!rstN)
    (strb.parityOn && strb.evenSense) |-> !(^arrayWrData));

endmodule

// File: rtl/bwp_front.sv
module bwp_front
  import bwp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 globalWrN,
  input  logic                 byteWrN,
  input  logic [LANES-1:0]     laneSelN,
  input  logic                 parityEnN,
  input  logic                 evenSel,
  input  logic [LANES*8-1:0]   wrData,
  input  logic                 rdValid,
  input  logic [LANES*9-1:0]   rdWord,
  output logic [LANES-1:0]     laneWe,
  output logic [LANES*9-1:0]   arrayWrData,
  output logic                 rdBeatValid,
  output logic [LANES*8-1:0]   rdBeatData,
  output logic                 parErrN
);

  bwpStrobes_t strb;

  bwp_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .globalWrN(globalWrN), .byteWrN(byteWrN),
    .laneSelN(laneSelN), .parityEnN(parityEnN), .evenSel(evenSel),
    .rdValid(rdValid), .laneWe(laneWe), .strb(strb)
  );

  bwp_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdWord(rdWord),
    .arrayWrData(arrayWrData), .rdBeatValid(rdBeatValid),
    .rdBeatData(rdBeatData), .parErrN(parErrN)
  );

  // R9: reset values, checked while reset is held.
  always @(posedge clk) begin
    if (!rstN) begin
      a_r9_reset_state: assert (laneWe == '0 && parErrN && !rdBeatValid);
    end
  end

endmodule

// File: tb/tb_bwp_front.sv
module tb_bwp_front;
  localparam int  LANES  = 4;
  localparam time PERIOD = 10;

  logic               clk = 0;
  logic               rstN = 0;
  logic               globalWrN = 1, byteWrN = 1, parityEnN = 0, evenSel = 1, rdValid = 0;
  logic [LANES-1:0]   laneSelN = '1;
  logic [LANES*8-1:0] wrData = '0;
  logic [LANES*9-1:0] rdWord = '0;
  logic [LANES-1:0]   laneWe;
  logic [LANES*9-1:0] arrayWrData;
  logic               rdBeatValid;
  logic [LANES*8-1:0] rdBeatData;
  logic               parErrN;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic [LANES-1:0]   we;
    logic [LANES*9-1:0] aw;
    logic               rv;
    logic [LANES*8-1:0] rd;
    logic               errN;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  bwp_front #(.LANES(LANES)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [LANES*9-1:0] packWord(logic [LANES*8-1:0] d, logic penN, logic ev,
                                                  logic [LANES-1:0] corrupt);
    logic [LANES*9-1:0] w;
    for (int i = 0; i < LANES; i++) begin
      logic [7:0] b;
      logic p;
      b = d[8*i +: 8];
      p = penN ? 1'b0 : ((^b) ^ !ev);
      w[9*i +: 9] = {p ^ corrupt[i], b};
    end
    return w;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic cyc(string tag, logic gN, logic bN, logic [LANES-1:0] sel, logic penN,
                     logic ev, logic [LANES*8-1:0] wd, logic rv, logic [LANES*9-1:0] rw);
    exp_t e;
    logic bad;
    @(negedge clk);
    globalWrN = gN; byteWrN = bN; laneSelN = sel; parityEnN = penN; evenSel = ev;
    wrData = wd; rdValid = rv; rdWord = rw;
    e.we = !gN ? '1 : (!bN ? ~sel : '0);
    e.aw = packWord(wd, penN, ev, '0);
    e.rv = rv;
    bad = 1'b0;
    for (int i = 0; i < LANES; i++) bad |= (^rw[9*i +: 9]) ^ !ev;
    e.errN = !(rv && !penN && bad);
    for (int i = 0; i < LANES; i++) e.rd[8*i +: 8] = rw[9*i +: 8];
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, "laneWe", 64'(laneWe), 64'(e.we));
      check(t, "arrayWrData", 64'(arrayWrData), 64'(e.aw));
      check(t, "rdBeatValid", 64'(rdBeatValid), 64'(e.rv));
      check(t, "parErrN", 64'(parErrN), 64'(e.errN));
      if (e.rv) check(t, "rdBeatData", 64'(rdBeatData), 64'(e.rd));
    end
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // R9: reset values while held
    repeat (3) @(negedge clk);
    globalWrN = 0; rdValid = 1; rdWord = '1; parityEnN = 0;
    @(negedge clk);
    check("R9", "laneWe", 64'(laneWe), 64'(0));
    check("R9", "parErrN", 64'(parErrN), 64'(1));
    check("R9", "rdBeatValid", 64'(rdBeatValid), 64'(0));
    globalWrN = 1; rdValid = 0; rdWord = '0;
    rstN = 1;

    // R2: global write wins over selects
    cyc("R2", 0, 1, 4'b1111, 0, 1, 32'h1122_3344, 0, '0);
    cyc("R2", 0, 0, 4'b1010, 0, 1, 32'h5566_7788, 0, '0);
    // R3: byte write by select
    cyc("R3", 1, 0, 4'b0101, 0, 1, 32'hA5A5_0F0F, 0, '0);
    cyc("R3", 1, 0, 4'b1110, 0, 1, 32'h0000_00FF, 0, '0);
    cyc("R3", 1, 0, 4'b1111, 0, 1, 32'hDEAD_BEEF, 0, '0);
    // R4: no enables
    cyc("R4", 1, 1, 4'b0000, 0, 1, 32'h1234_5678, 0, '0);
    // R5: even and odd parity generation
    cyc("R5", 0, 1, 4'b1111, 0, 1, 32'h0103_07FF, 0, '0);
    cyc("R5", 0, 1, 4'b1111, 0, 0, 32'h0103_07FF, 0, '0);
    // R6: parity off writes zero parity bits
    cyc("R6", 0, 1, 4'b1111, 1, 1, 32'h0103_07FF, 0, '0);
    cyc("R6", 0, 1, 4'b1111, 1, 0, 32'hFE01_8000, 0, '0);
    // R7 / R10: clean, corrupt, clean reads in both senses
    d = 32'hC3A5_7E01;
    cyc("R10", 1, 1, 4'b1111, 0, 1, '0, 1, packWord(d, 0, 1, 4'b0000));
    cyc("R7", 1, 1, 4'b1111, 0, 1, '0, 1, packWord(d, 0, 1, 4'b0100));
    cyc("R7", 1, 1, 4'b1111, 0, 1, '0, 1, packWord(d, 0, 1, 4'b0000));
    cyc("R7", 1, 1, 4'b1111, 0, 0, '0, 1, packWord(d, 0, 0, 4'b0000));
    cyc("R7", 1, 1, 4'b1111, 0, 0, '0, 1, packWord(d, 0, 0, 4'b1000));
    cyc("R7", 1, 1, 4'b1111, 0, 0, '0, 0, packWord(d, 0, 0, 4'b1111));
    // R8: parity off, corrupted lanes are ignored
    cyc("R8", 1, 1, 4'b1111, 1, 1, '0, 1, packWord(d, 0, 1, 4'b1111));
    cyc("R8", 1, 1, 4'b1111, 1, 0, '0, 1, packWord(d, 0, 0, 4'b0010));
    // R1: inputs changing every cycle
    for (int k = 0; k < 8; k++) begin
      cyc("R1", k[0], k[1], 4'(k * 5), k[2], k[0], 32'(k * 32'h1357_9BDF), k[1],
          packWord(32'(k * 32'h2468_ACE1), 0, k[0], 4'(k)));
    end
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule